// File: doc/BRIEF.md
# Overload Fault Integrating Timer

This block supervises faults for a current-mode switching controller. A synchronous over-current flag from the peak-current comparator feeds a saturating up/down counter. The counter advances on a periodic tick made from the system clock. It counts up on ticks where the flag is high and down on ticks where it is low. Short bursts of overload therefore cancel against quiet periods, and a fault is declared only when the net overload reaches a fixed number of ticks. With the default settings that is eight ticks of 10 ms, or 80 ms.

A separate winding-short flag, from a faster comparator, stops the driver at once without counting. A static strap chooses what happens after either fault:

- **Auto-recovery:** switching stops, and the block waits for the supply to discharge to its turn-off threshold. It then restarts from startup. A fault that persists therefore gives a low duty-cycle burst pattern.
- **Latched:** driver pulses stop and the supply is held at its latch level. The block stays latched until a release input reports that supply current has dropped below the hold level.

The analog comparators, blanking and regulation are outside the block and reach it as digital inputs.

Top module: `ovld_guard`

## Requirements
- R1: While `rst_n` is low, `drv_en` is 0. From reset the block is in the run state (`st_run`=1, `st_wait`=0, `st_latched`=0, `stop_req`=0) with the counter and tick prescaler at zero.
- R2: While running, a tick occurs once every `TICK_DIV` clock cycles, counted from reset or from the latest restart. On a tick with `oc_flag`=1 the counter rises by one.
- R3: On a tick with `oc_flag`=0 the counter falls by one and saturates at zero. Overload that clears before the net count reaches `FAULT_TICKS` causes no fault.
- R4: A tick with `oc_flag`=1 while the count equals `FAULT_TICKS`-1 is completion. `drv_en` goes low in that same cycle, and from the next cycle `stop_req`=1 with the fault state shown on the status outputs.
- R5: With `latch_mode`=0 a fault enters the wait state (`st_wait`=1). It stays there until `supply_low`=1, and then returns to run on the next edge with the counter and prescaler cleared.
- R6: With `latch_mode`=1 a fault enters the latched state (`st_latched`=1). It stays there until `hold_release`=1 and then returns to run, cleared in the same way. `supply_low` has no effect while latched.
- R7: `short_flag`=1 in the run state drops `drv_en` in the same cycle and enters the wait or latched state chosen by `latch_mode`, with no counting.
- R8: Exactly one of `st_run`, `st_wait` and `st_latched` is high at any time. `stop_req` is high exactly when the block is not running.
- R9: `hold_release` and `supply_low` have no effect in the run state. `hold_release` has no effect in the wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| latch_mode | input | 1 | Strap: 1 = latched policy, 0 = auto-recovery policy |
| oc_flag | input | 1 | Synchronous peak over-current flag |
| short_flag | input | 1 | Synchronous winding-short flag |
| supply_low | input | 1 | Supply has fallen to its turn-off threshold |
| hold_release | input | 1 | Supply current has fallen below the latch hold level |
| drv_en | output | 1 | Gate driver enable |
| stop_req | output | 1 | Stop switching / discharge-or-hold request |
| st_run | output | 1 | Status: running |
| st_wait | output | 1 | Status: auto-recovery wait |
| st_latched | output | 1 | Status: latched |

## Verification
The properties assume that every input is already synchronous to `clk`. They also assume that `latch_mode` is settled in the cycle a fault is detected, because that cycle picks the state the block enters. The stimulus changes inputs only one time unit after a rising edge, and it changes `latch_mode` only while the block is running with no fault pending. It also pulses `supply_low` and `hold_release` in states where they must be ignored, so that the cases the properties do not restrict are still covered. The reference model in the bench follows every count that crosses zero or reaches the limit, so a misplaced saturation or completion shows up as a cycle offset in `drv_en`.

// File: rtl/ovld_guard_pkg.sv
// Package: shared state encoding for the overload fault supervisor.
// Assumes: nothing beyond IEEE 1800-2017.
package ovld_guard_pkg;
    typedef enum logic [1:0] {
        GS_RUN   = 2'd0,
        GS_WAIT  = 2'd1,
        GS_LATCH = 2'd2
    } guard_state_t;
endpackage

// File: rtl/ovld_tick_gen.sv
// Module: divides the system clock into a one-cycle fault tick.
// Assumes: TICK_DIV >= 2. The count is held at zero whenever en is low, so
// ticks restart their phase from every startup.
module ovld_tick_gen #(
    parameter int TICK_DIV = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] div_q;

    // Purpose: free-running divider, cleared when not enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // Purpose: tick flags the last cycle of each division period.
    always_comb begin
        tick = (div_q == LAST);
    end
endmodule

// File: rtl/ovld_integrator.sv
// Module: saturating up/down counter of overload ticks.
// Assumes: FAULT_TICKS >= 2. clr has priority over tick. The count never
// passes FAULT_TICKS-1 because the caller clears on completion.
module ovld_integrator #(
    parameter int FAULT_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic oc,
    output logic at_limit
);
    localparam int CW = (FAULT_TICKS > 2) ? $clog2(FAULT_TICKS) : 1;
    localparam logic [CW-1:0] TOP = CW'(FAULT_TICKS - 1);

    logic [CW-1:0] cnt_q;

    // Purpose: integrate over-current ticks up, quiet ticks down, floor at 0.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (oc) begin
                if (cnt_q != TOP) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Purpose: one more over-current tick completes the timer.
    always_comb begin
        at_limit = (cnt_q == TOP);
    end
endmodule

// File: rtl/ovld_policy.sv
// Module: run / auto-recovery wait / latched state machine.
// Assumes: inputs synchronous to clk. latch_mode is sampled in the cycle a
// fault is detected.
module ovld_policy
    import ovld_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic latch_mode,
    input  logic oc,
    input  logic short_flag,
    input  logic tick,
    input  logic at_limit,
    input  logic supply_low,
    input  logic hold_release,
    output logic running,
    output logic trip,
    output logic stop_req,
    output logic st_run,
    output logic st_wait,
    output logic st_latched
);
    guard_state_t state_q, state_d;

    // Purpose: detect completion or winding short while running.
    always_comb begin
        running = (state_q == GS_RUN);
        trip    = running && (short_flag || (tick && oc && at_limit));
    end

    // Purpose: next-state selection by fault policy and release inputs.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_RUN:   if (trip) state_d = latch_mode ? GS_LATCH : GS_WAIT;
            GS_WAIT:  if (supply_low) state_d = GS_RUN;
            GS_LATCH: if (hold_release) state_d = GS_RUN;
            default:  state_d = GS_RUN;
        endcase
    end

    // Purpose: state register and registered fault/status outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= GS_RUN;
            stop_req   <= 1'b0;
            st_run     <= 1'b1;
            st_wait    <= 1'b0;
            st_latched <= 1'b0;
        end else begin
            state_q    <= state_d;
            stop_req   <= (state_d != GS_RUN);
            st_run     <= (state_d == GS_RUN);
            st_wait    <= (state_d == GS_WAIT);
            st_latched <= (state_d == GS_LATCH);
        end
    end
endmodule

// File: rtl/ovld_guard.sv
// Module: overload fault integrating timer (top).
// Assumes: all flags synchronous to clk. The default TICK_DIV gives 10 ms
// ticks at 125 MHz. drv_en drops combinationally in the cycle a fault is
// detected. All other outputs are registered.
module ovld_guard #(
    parameter int TICK_DIV    = 1250000,
    parameter int FAULT_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic latch_mode,
    input  logic oc_flag,
    input  logic short_flag,
    input  logic supply_low,
    input  logic hold_release,
    output logic drv_en,
    output logic stop_req,
    output logic st_run,
    output logic st_wait,
    output logic st_latched
);
    logic tick, at_limit, running, trip;
    logic div_en, cnt_clr;

    // Purpose: the prescaler and counter run only while switching, and clear on a fault.
    always_comb begin
        div_en  = running && !trip;
        cnt_clr = !running || trip;
    end

    ovld_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (div_en),
        .tick  (tick)
    );

    ovld_integrator #(.FAULT_TICKS(FAULT_TICKS)) u_int (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .tick     (tick),
        .oc       (oc_flag),
        .at_limit (at_limit)
    );

    ovld_policy u_pol (
        .clk          (clk),
        .rst_n        (rst_n),
        .latch_mode   (latch_mode),
        .oc           (oc_flag),
        .short_flag   (short_flag),
        .tick         (tick),
        .at_limit     (at_limit),
        .supply_low   (supply_low),
        .hold_release (hold_release),
        .running      (running),
        .trip         (trip),
        .stop_req     (stop_req),
        .st_run       (st_run),
        .st_wait      (st_wait),
        .st_latched   (st_latched)
    );

    // Purpose: the driver runs only out of reset, in run, with no fault this cycle.
    always_comb begin
        drv_en = rst_n && running && !trip;
    end
endmodule

// File: rtl/ovld_guard_chk.sv
// Module: port-level properties of the overload supervisor, bound to the top.
// Assumes: inputs synchronous to clk.
module ovld_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic latch_mode,
    input logic oc_flag,
    input logic short_flag,
    input logic supply_low,
    input logic hold_release,
    input logic drv_en,
    input logic stop_req,
    input logic st_run,
    input logic st_wait,
    input logic st_latched
);
    // R8
    status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({st_run, st_wait, st_latched}) == 1);

    // R8
    stop_vs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req == !st_run);

    // R4
    drv_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> st_run);

    // R7
    short_kills_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_run && short_flag) |-> !drv_en);

    // R7
    short_leaves_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_run && short_flag) |=> (st_wait || st_latched));

    // R5
    wait_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wait && supply_low) |=> st_run);

    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_latched && !hold_release) |=> st_latched);

    // R3
    quiet_stays_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_run && !oc_flag && !short_flag) |=> st_run);
endmodule

bind ovld_guard ovld_guard_chk u_chk (.*);

// File: tb/ovld_guard_tb.sv
module ovld_guard_tb;
    localparam int DIV = 4;
    localparam int NT  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic latch_mode = 1'b0, oc_flag = 1'b0, short_flag = 1'b0;
    logic supply_low = 1'b0, hold_release = 1'b0;
    logic drv_en, stop_req, st_run, st_wait, st_latched;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    string phase = "R1 reset";

    // Model state: 0 run, 1 wait, 2 latched.
    int m_st = 0;
    int m_cnt = 0;
    int m_pre = 0;

    always #4 clk = ~clk;

    ovld_guard #(.TICK_DIV(DIV), .FAULT_TICKS(NT)) u_dut (
        .clk(clk), .rst_n(rst_n), .latch_mode(latch_mode), .oc_flag(oc_flag),
        .short_flag(short_flag), .supply_low(supply_low),
        .hold_release(hold_release), .drv_en(drv_en), .stop_req(stop_req),
        .st_run(st_run), .st_wait(st_wait), .st_latched(st_latched)
    );

    function automatic bit m_trip();
        return (m_st == 0) &&
               (short_flag || (m_pre == DIV-1 && oc_flag && m_cnt == NT-1));
    endfunction

    // Reference model update on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_pre = 0;
        end else if (m_st == 0) begin
            if (m_trip()) begin
                m_st = latch_mode ? 2 : 1; m_cnt = 0; m_pre = 0;
            end else if (m_pre == DIV-1) begin
                m_pre = 0;
                if (oc_flag) m_cnt = m_cnt + 1;
                else if (m_cnt > 0) m_cnt = m_cnt - 1;
            end else begin
                m_pre = m_pre + 1;
            end
        end else if (m_st == 1) begin
            if (supply_low) begin m_st = 0; m_cnt = 0; m_pre = 0; end
        end else begin
            if (hold_release) begin m_st = 0; m_cnt = 0; m_pre = 0; end
        end
    end

    // Compare every cycle away from the active edge.
    always @(negedge clk) begin
        logic [4:0] got, exp;
        if (!done) begin
            got = {drv_en, stop_req, st_run, st_wait, st_latched};
            exp = {rst_n && m_st == 0 && !m_trip(), m_st != 0,
                   m_st == 0, m_st == 1, m_st == 2};
            n_chk++;
            if (got !== exp) begin
                n_fail++;
                $display("FAIL %s t=%0t {drv,stop,run,wait,latch} got=%b exp=%b",
                         phase, $time, got, exp);
            end
        end
    end

    task automatic drive(input bit oc, input bit sh, input bit lo,
                         input bit hr, input int n);
        oc_flag = oc; short_flag = sh; supply_low = lo; hold_release = hr;
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        phase = "R2 R3 integrate";
        drive(1, 0, 0, 0, 5*DIV);
        drive(0, 0, 0, 0, 3*DIV);
        drive(1, 0, 0, 0, 4*DIV);
        drive(0, 0, 0, 0, 10*DIV);
        phase = "R9 ignored in run";
        drive(0, 0, 1, 1, 2*DIV);
        phase = "R3 saturate then R4 completion";
        drive(1, 0, 0, 0, NT*DIV + 4);
        phase = "R5 wait, R9 release ignored";
        drive(1, 0, 0, 1, 10);
        phase = "R5 restart";
        drive(1, 0, 1, 0, 1);
        drive(1, 0, 0, 0, NT*DIV + 6);
        drive(0, 0, 1, 0, 1);
        drive(0, 0, 0, 0, 5);
        latch_mode = 1'b1;
        phase = "R6 latched completion";
        drive(1, 0, 0, 0, NT*DIV + 4);
        phase = "R6 supply_low ignored";
        drive(1, 0, 1, 0, 10);
        drive(0, 0, 0, 1, 1);
        drive(0, 0, 0, 0, 6);
        phase = "R7 short latched";
        drive(1, 0, 0, 0, 3*DIV);
        drive(1, 1, 0, 0, 1);
        drive(0, 0, 0, 0, 6);
        drive(0, 0, 0, 1, 1);
        latch_mode = 1'b0;
        phase = "R7 short auto";
        drive(0, 0, 0, 0, 7);
        drive(0, 1, 0, 0, 1);
        drive(0, 0, 0, 0, 5);
        drive(0, 0, 1, 0, 1);
        phase = "R2 R4 after restart";
        drive(1, 0, 0, 0, NT*DIV + 3);
        drive(0, 0, 1, 0, 1);
        drive(0, 0, 0, 0, 4);
        phase = "R1 reset again";
        rst_n = 1'b0;
        drive(1, 0, 0, 0, 3);
        rst_n = 1'b1;
        drive(0, 0, 0, 0, 4);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired in phase %s", phase);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule